// File: doc/BRIEF.md
# TDM Audio Frame Sync Generator

This block creates and conditions the frame synchronization for one direction of a multichannel audio serial port. It counts bit clocks within a slot word and slots within a frame. It marks the first bit clock of every frame and drives a sync pulse of a chosen width and polarity. It also tells the serializer which bit clock carries the first data bit, after a chosen delay of 0, 1 or 2 bit clocks.

A single slot-count field selects the framing. The value 0 gives burst framing, where each word is requested separately. The value 2 gives two-slot framing. Values 3 to 32 give TDM with that many slots. The value 384 gives one long 384-slot frame. The sync source is also selectable. The block can generate it internally, follow an active edge on an external pin, or follow the frame mark of the sibling (transmit) direction. In the last two cases the block does not drive the pin. Every option can be changed at run time.

Top module: `tdm_fsync_gen`

## Requirements
- R1: For a slot count N of 2 to 32 or 384, the internal generator repeats a frame of N×SLOT_BITS bit clocks. The first frame begins on the first bit clock after reset is released.
- R2: `slot_idx` is 0 during the first SLOT_BITS bit clocks of a frame. It then advances by one every SLOT_BITS bit clocks and wraps from N-1 to 0.
- R3: With `cfg_wide`=0 the sync is active only on the first bit clock of a frame. With `cfg_wide`=1 it is active on all SLOT_BITS bit clocks of slot 0.
- R4: `fs_out` equals the active-sync level XOR `cfg_pol`. So `cfg_pol`=0 makes the sync active high (rising edge), and `cfg_pol`=1 makes it active low (falling edge). When no sync is active, and during reset, `fs_out` equals `cfg_pol`.
- R5: `frame_start` pulses for one bit clock, `cfg_dly` bit clocks (0, 1 or 2) after the first bit clock of each frame.
- R6: With slot count 0 (burst), each `burst_req` cycle starts one single-slot frame on the next bit clock if the block is idle. If a word is in progress, one request is held and its frame starts right after the last bit of that word. With no request pending the block stays idle and drives no sync.
- R7: With `cfg_ext`=1 and `cfg_share`=0, `fs_oe` is 0 and `fs_out` stays at the idle level. The input `fs_pin_in` passes through SYNC_STAGES flops. An active edge on it (rising for `cfg_pol`=0, falling for `cfg_pol`=1) starts a frame SYNC_STAGES+1 bit clocks after the pin changes. An edge in mid-frame restarts the frame. The opposite edge is ignored. With no further edge, the block goes idle after one frame.
- R8: With `cfg_share`=1, a frame begins on the bit clock after each `peer_mark` pulse. `fs_pin_in` is ignored and `fs_oe` is 0.
- R9: The configuration is invalid if the slot count is 1, 33 to 383, or 385 to 511, or if `cfg_dly`=3. An invalid configuration sets `cfg_err` to 1 and holds the block idle: no sync, no `frame_mark` and no `frame_start`.
- R10: `frame_mark` pulses for exactly one bit clock, on the first bit clock of every frame, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ext | input | 1 | 1: follow external sync pin |
| cfg_share | input | 1 | 1: follow the sibling direction's frame mark (takes precedence) |
| cfg_pol | input | 1 | 0: active-high sync, 1: active-low sync |
| cfg_wide | input | 1 | 0: one-bit sync, 1: one-slot-word sync |
| cfg_slots | input | 9 | Slots per frame: 0 burst, 2..32, or 384 |
| cfg_dly | input | 2 | Bit clocks from frame begin to first data bit (0..2) |
| burst_req | input | 1 | Word request in burst framing |
| peer_mark | input | 1 | Frame mark from the sibling direction |
| fs_pin_in | input | 1 | External sync pin level |
| fs_out | output | 1 | Sync level to drive on the pin |
| fs_oe | output | 1 | Pin drive enable (internal source only) |
| frame_mark | output | 1 | First bit clock of a frame |
| frame_start | output | 1 | Bit clock of the first data bit |
| slot_idx | output | 9 | Current slot within the frame |
| cfg_err | output | 1 | Invalid configuration |

## Verification
The bench builds the block with SLOT_BITS=4 and SYNC_STAGES=2. With a four-bit slot, the full 384-slot frame takes 1536 bit clocks, so two back-to-back frames and their wrap fit in a short run. The largest data delay still falls inside slot 0, which keeps the slot index at every strobe predictable. The two-flop synchronizer gives a fixed three-clock path from the pin to the frame. This lets the bench place mid-frame restarts and ignored opposite edges on exact cycles.

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen #(
  parameter int SLOT_BITS   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_ext,
  input  logic       cfg_share,
  input  logic       cfg_pol,
  input  logic       cfg_wide,
  input  logic [8:0] cfg_slots,
  input  logic [1:0] cfg_dly,
  input  logic       burst_req,
  input  logic       peer_mark,
  input  logic       fs_pin_in,
  output logic       fs_out,
  output logic       fs_oe,
  output logic       frame_mark,
  output logic       frame_start,
  output logic [8:0] slot_idx,
  output logic       cfg_err
);

  localparam int            BW       = (SLOT_BITS > 2) ? $clog2(SLOT_BITS) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(SLOT_BITS - 1);

  logic                   active_q;
  logic                   req_pend_q;
  logic [BW-1:0]          bit_q;
  logic [8:0]             slot_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   d1_q, d2_q;

  logic       mode_burst, slots_ok, follow;
  logic [8:0] n_eff;
  logic       last_bit, last_slot, frame_end;
  logic       want, pin_evt, ext_evt, start;
  logic       fs_lvl;

  assign mode_burst = (cfg_slots == 9'd0);
  assign slots_ok   = mode_burst || (cfg_slots >= 9'd2 && cfg_slots <= 9'd32) || (cfg_slots == 9'd384);
  assign cfg_err    = !slots_ok || (cfg_dly == 2'd3);
  assign follow     = cfg_share || cfg_ext;
  assign n_eff      = mode_burst ? 9'd1 : cfg_slots;

  assign last_bit   = (bit_q == LAST_BIT);
  assign last_slot  = (slot_q >= n_eff - 9'd1);
  assign frame_end  = active_q && last_bit && last_slot;
  assign want       = req_pend_q || burst_req;

  assign pin_evt = cfg_pol ? (prev_q & ~sync_q[SYNC_STAGES-1])
                           : (~prev_q & sync_q[SYNC_STAGES-1]);
  assign ext_evt = cfg_share ? peer_mark : pin_evt;

  always_comb begin
    if (follow)          start = ext_evt;
    else if (mode_burst) start = (!active_q || frame_end) && want;
    else                 start = !active_q || frame_end;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q[0] <= fs_pin_in;
      for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (cfg_err) begin
      active_q <= 1'b0;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      bit_q    <= '0;
      slot_q   <= '0;
    end else if (active_q) begin
      if (frame_end) begin
        active_q <= 1'b0;
        bit_q    <= '0;
        slot_q   <= '0;
      end else if (last_bit) begin
        bit_q  <= '0;
        slot_q <= slot_q + 9'd1;
      end else begin
        bit_q <= bit_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       req_pend_q <= 1'b0;
    else if (cfg_err || follow || !mode_burst) req_pend_q <= 1'b0;
    else if (start)                   req_pend_q <= req_pend_q & burst_req;
    else                              req_pend_q <= req_pend_q | burst_req;
  end

  assign frame_mark = active_q && (bit_q == '0) && (slot_q == 9'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1_q <= 1'b0;
      d2_q <= 1'b0;
    end else begin
      d1_q <= frame_mark;
      d2_q <= d1_q;
    end
  end

  always_comb begin
    case (cfg_dly)
      2'd0:    frame_start = frame_mark;
      2'd1:    frame_start = d1_q;
      2'd2:    frame_start = d2_q;
      default: frame_start = 1'b0;
    endcase
  end

  assign slot_idx = slot_q;
  assign fs_oe    = !follow;
  assign fs_lvl   = fs_oe && active_q && (slot_q == 9'd0) && (cfg_wide || bit_q == '0);
  assign fs_out   = fs_lvl ^ cfg_pol;

  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |=> !frame_mark);

  p_narrow_sync_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fs_oe && !cfg_wide && (fs_out != cfg_pol)
    |=> (fs_out == cfg_pol) || cfg_wide || !fs_oe || !$stable(cfg_pol));

  p_start_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark && (cfg_dly == 2'd1) |=> frame_start || (cfg_dly != 2'd1));

  p_burst_needs_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_mark && $past(mode_burst && !follow && !cfg_err) |-> $past(req_pend_q || burst_req));

endmodule

// File: tb/tb_tdm_fsync_gen.sv
module tb_tdm_fsync_gen;
  localparam int SB = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_ext = 1'b0, cfg_share = 1'b0, cfg_pol = 1'b0, cfg_wide = 1'b0;
  logic [8:0] cfg_slots = 9'd2;
  logic [1:0] cfg_dly = 2'd0;
  logic       burst_req = 1'b0, peer_mark = 1'b0, fs_pin_in = 1'b0;
  logic       fs_out, fs_oe, frame_mark, frame_start, cfg_err;
  logic [8:0] slot_idx;

  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  int exp_q[$];

  tdm_fsync_gen #(.SLOT_BITS(SB), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_ext(cfg_ext), .cfg_share(cfg_share),
    .cfg_pol(cfg_pol), .cfg_wide(cfg_wide), .cfg_slots(cfg_slots), .cfg_dly(cfg_dly),
    .burst_req(burst_req), .peer_mark(peer_mark), .fs_pin_in(fs_pin_in),
    .fs_out(fs_out), .fs_oe(fs_oe), .frame_mark(frame_mark), .frame_start(frame_start),
    .slot_idx(slot_idx), .cfg_err(cfg_err));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d cycle=%0d", req, act, exp, cyc);
    end
  endtask

  // scoreboard monitor: frame_start strobes against queued expected cycles (R5)
  always @(negedge clk) begin
    if (rst_n && frame_start) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected frame_start", cyc, -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(e == cyc, "R5 frame_start cycle", cyc, e);
      end
      chk(slot_idx == 9'd0, "R2 slot at first data bit", slot_idx, 0);
    end
  end

  task automatic begin_case(input bit ext, input bit share, input bit pol, input bit wide,
                            input int slots, input int dly, output int t0);
    @(negedge clk); #1;
    rst_n = 1'b0; cfg_ext = ext; cfg_share = share; cfg_pol = pol; cfg_wide = wide;
    cfg_slots = 9'(slots); cfg_dly = 2'(dly); burst_req = 1'b0; peer_mark = 1'b0;
    fs_pin_in = pol;
    @(negedge clk);
    chk(fs_out == pol, "R4 reset idle level", fs_out, pol);
    chk(!frame_mark && !frame_start, "R10 reset quiet", frame_mark, 0);
    chk(slot_idx == 9'd0, "R2 reset slot", slot_idx, 0);
    #1; rst_n = 1'b1; t0 = cyc;
  endtask

  task automatic end_case();
    chk(exp_q.size() == 0, "R5 missing frame_start", exp_q.size(), 0);
    exp_q.delete();
    #1; rst_n = 1'b0;
  endtask

  task automatic tdm_case(input int slots, input int dly, input bit wide, input bit pol,
                          input int frames);
    int t0, p;
    p = slots * SB;
    begin_case(1'b0, 1'b0, pol, wide, slots, dly, t0);
    for (int k = 0; k < frames; k++) exp_q.push_back(t0 + 1 + dly + k * p);
    for (int i = 1; i <= frames * p; i++) begin
      int pos;
      bit act;
      @(negedge clk);
      pos = (cyc - t0 - 1) % p;
      act = wide ? (pos < SB) : (pos == 0);
      if (i == 1) chk(cfg_err == 1'b0, "R9 valid config flag", cfg_err, 0);
      chk(fs_out == (act ^ pol), wide ? "R3 wide sync" : "R3 narrow sync", fs_out, act ^ pol);
      chk(fs_oe == 1'b1, "R1 internal drive", fs_oe, 1);
      chk(slot_idx == 9'(pos / SB), "R2 slot index", slot_idx, pos / SB);
      chk(frame_mark == (pos == 0), "R10 frame mark", frame_mark, pos == 0);
    end
    end_case();
  endtask

  task automatic burst_case();
    int t0;
    begin_case(1'b0, 1'b0, 1'b0, 1'b1, 0, 0, t0);
    burst_req = 1'b1;
    exp_q.push_back(t0 + 1); exp_q.push_back(t0 + 5); exp_q.push_back(t0 + 15);
    for (int i = 1; i <= 22; i++) begin
      int c;
      bit act;
      @(negedge clk);
      c = cyc - t0;
      act = (c >= 1 && c <= 8) || (c >= 15 && c <= 18);
      chk(fs_out == act, "R6 burst sync", fs_out, act);
      chk(frame_mark == (c == 1 || c == 5 || c == 15), "R6 burst frame mark", frame_mark,
          c == 1 || c == 5 || c == 15);
      #1; burst_req = (c == 2 || c == 14);
    end
    end_case();
  endtask

  task automatic ext_case();
    int t0;
    begin_case(1'b1, 1'b0, 1'b1, 1'b0, 4, 2, t0);
    exp_q.push_back(t0 + 10); exp_q.push_back(t0 + 20);
    for (int i = 1; i <= 45; i++) begin
      int c;
      @(negedge clk);
      c = cyc - t0;
      chk(fs_oe == 1'b0, "R7 no drive in external mode", fs_oe, 0);
      chk(fs_out == 1'b1, "R7 idle level held", fs_out, 1);
      chk(frame_mark == (c == 8 || c == 18), "R7 external frame mark", frame_mark, c == 8 || c == 18);
      #1;
      if (c == 5 || c == 15) fs_pin_in = 1'b0;
      if (c == 7 || c == 17) fs_pin_in = 1'b1;
    end
    end_case();
  endtask

  task automatic share_case();
    int t0;
    begin_case(1'b0, 1'b1, 1'b0, 1'b0, 2, 0, t0);
    exp_q.push_back(t0 + 4);
    for (int i = 1; i <= 30; i++) begin
      int c;
      @(negedge clk);
      c = cyc - t0;
      chk(fs_oe == 1'b0, "R8 no drive when sharing", fs_oe, 0);
      chk(frame_mark == (c == 4), "R8 shared frame mark", frame_mark, c == 4);
      if (c >= 4 && c <= 11) chk(slot_idx == 9'((c - 4) / SB), "R8 shared slot", slot_idx, (c - 4) / SB);
      #1;
      peer_mark = (c == 3);
      fs_pin_in = (c >= 10 && c < 14);
    end
    end_case();
  endtask

  task automatic bad_case(input int slots, input int dly);
    int t0;
    begin_case(1'b0, 1'b0, 1'b0, 1'b1, slots, dly, t0);
    burst_req = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      if (i == 1) chk(cfg_err == 1'b1, "R9 error flag", cfg_err, 1);
      chk(fs_out == 1'b0 && !frame_mark, "R9 held idle", fs_out | frame_mark, 0);
    end
    end_case();
  endtask

  initial begin
    tdm_case(2, 1, 1'b0, 1'b0, 3);
    tdm_case(3, 2, 1'b1, 1'b1, 2);
    tdm_case(32, 0, 1'b0, 1'b0, 1);
    tdm_case(384, 0, 1'b1, 1'b0, 2);
    burst_case();
    ext_case();
    share_case();
    bad_case(1, 0);
    bad_case(33, 1);
    bad_case(100, 0);
    bad_case(2, 3);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule